// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Interface

This block is the digital front end of a four-channel, 12-bit serial converter. A host sends 24-bit frames over a three-wire serial link made of an active-low frame select, a serial clock and a data line. Each frame carries a command and a channel address. The block keeps two 12-bit registers per channel. The staging register receives new codes. The output register holds the code that the converter is actually driving. The block also keeps a 4-bit per-channel update-mode register and an on/off bit for the internal reference.

The mode register lets some channels be held back while others are not. A channel whose mode bit is clear changes its output register only when a command or the hardware load strobe orders it. A channel whose mode bit is set is transparent: every write to its staging register also appears on its output at the end of the frame. This lets a host stage a group of channels and release them together, while the remaining channels follow each write straight away.

All serial pins and the load strobe are oversampled in one system clock domain. The serial clock must therefore run well below the system clock.

Top module: `quad_dac_if`

## Requirements
- R1: After reset, all four staging registers and all four output codes are 0, every mode bit is 0 and the reference enable is 0.
- R2: While `cs_n` is low, one bit is taken from `sdi` on each falling edge of `sclk`, most significant bit first. A frame ends at its 24th bit. In the frame, bits 23:22 are ignored, bits 21:19 are the command, bits 18:16 are the address and bits 15:4 are the 12-bit code.
- R3: If `cs_n` rises before 24 bits have arrived, the frame is dropped and no register changes.
- R4: Command 000 writes the code into the addressed staging register. It does not change the output code of a channel whose mode bit is 0.
- R5: Command 001 copies the addressed staging register into that channel's output code.
- R6: Command 011 writes the code into the addressed staging register and updates that channel's output code in the same frame.
- R7: Command 010 writes the addressed staging register first. It then copies all four staging registers into their output codes.
- R8: Address 0 to 3 selects channel A to D, and address 111 selects all four channels. Addresses 100 to 110 select no channel for data commands.
- R9: Command 110 loads the mode register from frame bits 3:0, with bit 0 for channel A up to bit 3 for channel D. The address and bits 15:4 are ignored.
- R10: When a channel's mode bit is 1, any write to its staging register also sets its output code to the new value when the frame ends.
- R11: Command 111 sets the reference enable from frame bit 0, where 1 means on. The other bits are ignored, and no code changes.
- R12: A falling edge on `load_n` copies all four staging registers into their output codes.
- R13: Commands 100 and 101 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Active-low load strobe; a falling edge updates all channels |
| dac_codes | output | 48 | Output codes: channel A in bits 11:0, then B, C, D |
| ref_en | output | 1 | Internal reference enable |

## Verification
The staging registers are not visible at the ports. A wrong staging value stays hidden until an update command, a load strobe or a transparent write copies it to `dac_codes`. For that reason, each stimulus that only stages data is followed by an update, and the output is checked a few system clocks after the frame ends. A wrong mode bit shows up on the first write to that channel: the output either moves when it should hold, or holds when it should move. A frame counter that drifts shows as a dropped or misdecoded frame, which is visible as soon as the next frame ends.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int unsigned FRAME_BITS = 24;
    localparam int unsigned CODE_W     = 12;
    localparam int unsigned NUM_CH     = 4;
    localparam int unsigned CODE_LSB   = 4;

    localparam logic [2:0] CMD_WR_INP     = 3'b000;
    localparam logic [2:0] CMD_UPD_ONE    = 3'b001;
    localparam logic [2:0] CMD_WR_UPD_ALL = 3'b010;
    localparam logic [2:0] CMD_WR_UPD_ONE = 3'b011;
    localparam logic [2:0] CMD_MODE       = 3'b110;
    localparam logic [2:0] CMD_REF        = 3'b111;
    localparam logic [2:0] ADDR_ALL       = 3'b111;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic                  frm_vld,
    output logic [FRAME_BITS-1:0] frm_data
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic                  sclk_prev;
        logic [FRAME_BITS-1:0] shift;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = sclk_s;
        if (cs_s) begin
            st_d.cnt = '0;
        end else if (st_q.sclk_prev && !sclk_s && st_q.cnt < CNT_W'(FRAME_BITS)) begin
            st_d.shift = {st_q.shift[FRAME_BITS-2:0], sdi_s};
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.vld   = (st_q.cnt == CNT_W'(FRAME_BITS - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_vld  = st_q.vld;
    assign frm_data = st_q.shift;

    // R2: a completed frame is reported once
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);
    // R3: frame select high clears the bit count, so no completion follows
    p_short_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !frm_vld);
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAME_BITS));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frm_vld,
    input  logic [FRAME_BITS-1:0]          frm_data,
    input  logic                           load_s,
    output logic [NUM_CH-1:0][CODE_W-1:0]  dac_out,
    output logic                           ref_out
);
    typedef struct packed {
        logic                          load_prev;
        logic [NUM_CH-1:0][CODE_W-1:0] inp;
        logic [NUM_CH-1:0][CODE_W-1:0] dac;
        logic [NUM_CH-1:0]             mode;
        logic                          ref_on;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [2:0]        cmd, addr;
    logic [CODE_W-1:0] code;
    logic [NUM_CH-1:0] sel;
    logic              wr_en, upd_one, upd_all, load_fall;
    logic              unused_bits;

    assign cmd         = frm_data[21:19];
    assign addr        = frm_data[18:16];
    assign code        = frm_data[CODE_LSB +: CODE_W];
    assign unused_bits = ^frm_data[FRAME_BITS-1:22];
    assign load_fall   = st_q.load_prev && !load_s;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            sel[i] = (addr == ADDR_ALL) || (addr == 3'(i));
        wr_en   = frm_vld && (cmd == CMD_WR_INP || cmd == CMD_WR_UPD_ALL
                              || cmd == CMD_WR_UPD_ONE);
        upd_one = frm_vld && (cmd == CMD_UPD_ONE || cmd == CMD_WR_UPD_ONE);
        upd_all = (frm_vld && cmd == CMD_WR_UPD_ALL) || load_fall;
    end

    always_comb begin
        st_d           = st_q;
        st_d.load_prev = load_s;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && sel[i])
                st_d.inp[i] = code;
            if (upd_all || (upd_one && sel[i]) || (wr_en && sel[i] && st_q.mode[i]))
                st_d.dac[i] = st_d.inp[i];
        end
        if (frm_vld && cmd == CMD_MODE)
            st_d.mode = frm_data[NUM_CH-1:0];
        if (frm_vld && cmd == CMD_REF)
            st_d.ref_on = frm_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.load_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) dac_out[i] = st_q.dac[i];
    end
    assign ref_out = st_q.ref_on;

    // R11: reference bit moves only after a reference frame
    p_ref_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ref_on) |-> $past(frm_vld && cmd == CMD_REF));
    // R9: mode bits move only after a mode frame
    p_mode_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> $past(frm_vld && cmd == CMD_MODE));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4: an output code moves only on a frame or a load strobe
        p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st_q.dac[g]) |-> $past(frm_vld || load_fall));
        // R10: transparent channel follows its staging register on a write
        p_transparent_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel[g] && st_q.mode[g]) |=> (st_q.dac[g] == st_q.inp[g]));
        // R12: load strobe leaves every output equal to its staging register
        p_load_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
            load_fall |=> (st_q.dac[g] == st_q.inp[g]));
    end
endmodule

// File: rtl/quad_dac_if.sv
module quad_dac_if
    import qdac_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    input  logic                       load_n,
    output logic [NUM_CH*CODE_W-1:0]   dac_codes,
    output logic                       ref_en
);
    logic [3:0]                    pins_s;
    logic                          frm_vld;
    logic [FRAME_BITS-1:0]         frm_data;
    logic [NUM_CH-1:0][CODE_W-1:0] dac_arr;

    qdac_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({load_n, cs_n, sclk, sdi}),
        .dout  (pins_s)
    );

    qdac_frame_rx i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .frm_vld  (frm_vld),
        .frm_data (frm_data)
    );

    qdac_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_vld  (frm_vld),
        .frm_data (frm_data),
        .load_s   (pins_s[3]),
        .dac_out  (dac_arr),
        .ref_out  (ref_en)
    );

    assign dac_codes = dac_arr;
endmodule

// File: tb/test_quad_dac_if.sv
module test_quad_dac_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        load_n = 1'b1;
    logic [47:0] dac_codes;
    logic        ref_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    quad_dac_if i_quad_dac_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .load_n(load_n), .dac_codes(dac_codes), .ref_en(ref_en)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] mk(logic [1:0] top, logic [2:0] cmd,
                                       logic [2:0] addr, logic [11:0] code,
                                       logic [3:0] low);
        return {top, cmd, addr, code, low};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag, logic [11:0] a, logic [11:0] b,
                           logic [11:0] c, logic [11:0] d);
        chk({tag, " chA"}, 32'(dac_codes[11:0]),  32'(a));
        chk({tag, " chB"}, 32'(dac_codes[23:12]), 32'(b));
        chk({tag, " chC"}, 32'(dac_codes[35:24]), 32'(c));
        chk({tag, " chD"}, 32'(dac_codes[47:36]), 32'(d));
    endtask

    task automatic send(logic [23:0] f, int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = f[23-i];
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_all("R1 reset", 12'h0, 12'h0, 12'h0, 12'h0);
        chk("R1 ref", 32'(ref_en), 0);
    endtask

    task automatic t_stage_and_update;
        send(mk(2'b11, 3'b000, 3'd0, 12'hABC, 4'hF), 24);
        chk_all("R4 stage only", 12'h0, 12'h0, 12'h0, 12'h0);
        send(mk(2'b10, 3'b001, 3'd0, 12'h000, 4'h0), 24);
        chk_all("R5 R2 update A", 12'hABC, 12'h0, 12'h0, 12'h0);
        send(mk(2'b01, 3'b011, 3'd1, 12'h123, 4'h5), 24);
        chk_all("R6 write+update B", 12'hABC, 12'h123, 12'h0, 12'h0);
    endtask

    task automatic t_update_all;
        send(mk(2'b00, 3'b000, 3'd2, 12'h456, 4'h0), 24);
        send(mk(2'b00, 3'b000, 3'd3, 12'h789, 4'h0), 24);
        chk_all("R4 staged C D", 12'hABC, 12'h123, 12'h0, 12'h0);
        send(mk(2'b00, 3'b010, 3'd0, 12'h111, 4'h0), 24);
        chk_all("R7 update all", 12'h111, 12'h123, 12'h456, 12'h789);
    endtask

    task automatic t_addr;
        send(mk(2'b00, 3'b000, 3'd5, 12'hFFF, 4'h0), 24);
        send(mk(2'b00, 3'b010, 3'd6, 12'hEEE, 4'h0), 24);
        chk_all("R8 addr 5/6 ignored", 12'h111, 12'h123, 12'h456, 12'h789);
        send(mk(2'b00, 3'b011, 3'd7, 12'h5A5, 4'h0), 24);
        chk_all("R8 broadcast", 12'h5A5, 12'h5A5, 12'h5A5, 12'h5A5);
    endtask

    task automatic t_short;
        send(mk(2'b00, 3'b011, 3'd0, 12'h0F0, 4'h0), 20);
        chk_all("R3 short frame", 12'h5A5, 12'h5A5, 12'h5A5, 12'h5A5);
        send(mk(2'b00, 3'b001, 3'd7, 12'h000, 4'h0), 24);
        chk_all("R3 short staged nothing", 12'h5A5, 12'h5A5, 12'h5A5, 12'h5A5);
    endtask

    task automatic t_reserved;
        send(mk(2'b00, 3'b100, 3'd7, 12'h333, 4'hF), 24);
        send(mk(2'b00, 3'b101, 3'd0, 12'h444, 4'h1), 24);
        chk("R13 ref", 32'(ref_en), 0);
        send(mk(2'b00, 3'b001, 3'd7, 12'h000, 4'h0), 24);
        chk_all("R13 reserved no effect", 12'h5A5, 12'h5A5, 12'h5A5, 12'h5A5);
    endtask

    task automatic t_mode;
        send(mk(2'b00, 3'b110, 3'd3, 12'hFFF, 4'b0101), 24);
        send(mk(2'b00, 3'b000, 3'd7, 12'h246, 4'h0), 24);
        chk_all("R10 R9 transparent A C", 12'h246, 12'h5A5, 12'h246, 12'h5A5);
        send(mk(2'b00, 3'b110, 3'd0, 12'h000, 4'b0000), 24);
        send(mk(2'b00, 3'b000, 3'd0, 12'h777, 4'h0), 24);
        chk_all("R9 mode cleared", 12'h246, 12'h5A5, 12'h246, 12'h5A5);
    endtask

    task automatic t_load;
        @(negedge clk) load_n = 1'b0;
        repeat (6) @(negedge clk);
        load_n = 1'b1;
        repeat (8) @(negedge clk);
        chk_all("R12 load strobe", 12'h777, 12'h246, 12'h246, 12'h246);
    endtask

    task automatic t_ref;
        send(mk(2'b11, 3'b111, 3'd2, 12'hFFF, 4'b1111), 24);
        chk("R11 ref on", 32'(ref_en), 1);
        chk_all("R11 codes kept", 12'h777, 12'h246, 12'h246, 12'h246);
        send(mk(2'b00, 3'b111, 3'd7, 12'hFFF, 4'b1110), 24);
        chk("R11 ref off", 32'(ref_en), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_stage_and_update;
        t_update_all;
        t_addr;
        t_short;
        t_reserved;
        t_mode;
        t_load;
        t_ref;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule